// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches one non-maskable interrupt pin and a parameterized set of maskable interrupt pins (four by default). Every pin passes through a two-flop synchronizer. A programmable edge detector follows, and each pin has its own polarity bit that selects a rising or a falling edge. When a maskable pin's pin-function bit makes it an interrupt input, a detected edge on that pin latches a pending flag. Software reads these flags and clears them by writing zeros. Each maskable source has its own enable bit, and each has its own vector number.

The block presents one request line and one vector number to the CPU. A pending non-maskable event always takes precedence, even when the CPU's global interrupt mask bit is set. That pending event clears itself when the CPU acknowledges it. Maskable requests reach the CPU only when the global mask is clear. Among them, the lowest-numbered pending and enabled pin is chosen.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0: polarity 0 is falling, pin-function off, enables off, flags clear. No request is raised, and `irq_vec` is 0.
- R2: The non-maskable pin's edge direction is set by register 0 bit 4 (1 = rising, 0 = falling). A detected edge sets the non-maskable pending bit, which reads as register 3 bit 4. The block then requests with vector `VEC_NMI` (7).
- R3: A pending non-maskable event requests with `VEC_NMI` whatever the value of `cpu_imask`, and it takes precedence over every maskable source.
- R4: Maskable pin n detects the edge selected by register 0 bit n (1 = rising). The edge sets flag bit n of register 3 only if pin-function bit n of register 1 is 1. Otherwise the edge is not recorded.
- R5: A write to register 3 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. Bit 4 of that write has no effect. If an edge is detected in the same cycle as a clearing write, the flag ends up set.
- R6: Enable bit n in register 2 gates only the request of source n. The flag is still set and still reads back when the enable bit is 0.
- R7: Among pending, enabled maskable sources, the lowest pin number wins, and the vector is `VEC_BASE` + n (16 + n).
- R8: While `cpu_imask` is 1 and no non-maskable event is pending, `irq_req` stays 0.
- R9: Pulsing `irq_ack` while the non-maskable event is pending clears its pending bit. An acknowledge does not clear maskable flags.
- R10: Changing a polarity bit while the pin is steady does not cause a detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pin | input | 1 | Non-maskable interrupt pin |
| irq_pin | input | NIRQ | Maskable interrupt pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 polarity, 1 pin function, 2 enable, 3 flags |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational |
| cpu_imask | input | 1 | CPU global interrupt mask bit |
| irq_ack | input | 1 | CPU acknowledge of the non-maskable request |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 8 | Vector number of the request |

## Verification
The assertions check four things on every cycle. A pending non-maskable event must drive the request with its vector, and the mask bit must block maskable requests. A flag must never drop without a clearing write, and a flag must never rise on a pin whose pin-function bit is off. Other behaviours can only be shown by the bench's scenarios. These include the polarity choice for each pin, the edge winning over a same-cycle clear, and a polarity change causing no detection. They also include the lowest-index priority and the exact vector numbers. A random phase changes pins, polarities, enables and the mask, and compares the flags and the request against a bench model.

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int NIRQ     = 4,
  parameter int DW       = 8,
  parameter int VW       = 8,
  parameter int VEC_NMI  = 7,
  parameter int VEC_BASE = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            nmi_pin,
  input  logic [NIRQ-1:0] irq_pin,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [1:0]      rd_addr,
  output logic [DW-1:0]   rd_data,
  input  logic            cpu_imask,
  input  logic            irq_ack,
  output logic            irq_req,
  output logic [VW-1:0]   irq_vec
);
  localparam int NP = NIRQ + 1;

  logic [NP-1:0]   sync1, sync2, prev, pol, edge_det;
  logic [NIRQ-1:0] pinfn, ena, flag, clr_keep, active;
  logic            nmi_pend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= {nmi_pin, irq_pin};
      sync2 <= sync1;
      prev  <= sync2;
    end

  assign edge_det = (pol & sync2 & ~prev) | (~pol & ~sync2 & prev);

  wire flag_wr = wr_en && (wr_addr == 2'd3);
  assign clr_keep = flag_wr ? wr_data[NIRQ-1:0] : '1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pol      <= '0;
      pinfn    <= '0;
      ena      <= '0;
      flag     <= '0;
      nmi_pend <= 1'b0;
    end else begin
      if (wr_en && wr_addr == 2'd0) pol   <= wr_data[NP-1:0];
      if (wr_en && wr_addr == 2'd1) pinfn <= wr_data[NIRQ-1:0];
      if (wr_en && wr_addr == 2'd2) ena   <= wr_data[NIRQ-1:0];
      flag     <= (flag & clr_keep) | (edge_det[NIRQ-1:0] & pinfn);
      nmi_pend <= edge_det[NIRQ] | (nmi_pend & ~irq_ack);
    end

  always_comb
    case (rd_addr)
      2'd0:    rd_data = DW'(pol);
      2'd1:    rd_data = DW'(pinfn);
      2'd2:    rd_data = DW'(ena);
      default: rd_data = DW'({nmi_pend, flag});
    endcase

  assign active = flag & ena & {NIRQ{~cpu_imask}};

  always_comb begin
    irq_req = 1'b0;
    irq_vec = '0;
    for (int i = NIRQ - 1; i >= 0; i--)
      if (active[i]) begin
        irq_req = 1'b1;
        irq_vec = VW'(VEC_BASE + i);
      end
    if (nmi_pend) begin
      irq_req = 1'b1;
      irq_vec = VW'(VEC_NMI);
    end
  end

  // R2/R3: pending non-maskable event owns the request
  p_nmi_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend |-> (irq_req && irq_vec == VW'(VEC_NMI)));

  p_mask_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_imask && !nmi_pend) |-> !irq_req);

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag & $past(flag & clr_keep)) == $past(flag & clr_keep)));

  p_pinfn_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag & ~$past(flag) & ~$past(pinfn)) == '0));
endmodule

// File: tb/ext_irq_ctrl_tb.sv
`timescale 1ns/1ps
module ext_irq_ctrl_tb;
  logic       clk = 0, rst_n = 0;
  logic       nmi_pin = 0, wr_en = 0, cpu_imask = 0, irq_ack = 0;
  logic [3:0] irq_pin = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data, irq_vec;
  logic       irq_req;
  int n_chk = 0, n_bad = 0;

  ext_irq_ctrl u_dut (.clk, .rst_n, .nmi_pin, .irq_pin, .wr_en, .wr_addr, .wr_data,
    .rd_addr, .rd_data, .cpu_imask, .irq_ack, .irq_req, .irq_vec);

  always #2.5 clk = ~clk;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a; #1 d = rd_data;
  endtask

  function automatic logic [8:0] exp_out(logic nmi, logic [3:0] fl, logic [3:0] en, logic im);
    if (nmi) return {1'b1, 8'd7};
    if (!im)
      for (int i = 0; i < 4; i++)
        if (fl[i] && en[i]) return {1'b1, 8'(16 + i)};
    return 9'd0;
  endfunction

  task automatic ack();
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
  endtask

  logic [7:0] d;
  logic [4:0] lvl, pol, nl, rise, fall, det;
  logic [3:0] pfn, en, fl;
  logic       nmi, im;

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1; tick(1);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d); check("R1 reg reset", d, 0);
    end
    check("R1 req reset", irq_req, 0);
    check("R1 vec reset", irq_vec, 0);

    // R4: edge without pin-function is ignored
    irq_pin[1] = 1; tick(4); irq_pin[1] = 0; tick(5);
    rd(3, d); check("R4 no pinfn", d, 0);

    // R4/R6: falling edge on pin 1 with pinfn, enable off
    wr(1, 8'h0F);
    irq_pin[1] = 1; tick(5);
    rd(3, d); check("R4 wrong edge", d, 0);
    irq_pin[1] = 0; tick(5);
    rd(3, d); check("R4 falling sets", d, 8'h02);
    check("R6 disabled no req", irq_req, 0);
    wr(2, 8'h0F); tick(1);
    check("R6 enabled req", irq_req, 1);
    check("R7 vec pin1", irq_vec, 17);

    // R8
    cpu_imask = 1; tick(1);
    check("R8 masked", irq_req, 0);
    cpu_imask = 0;

    // R7: pin 0 beats pin 1 (rising polarity on pin0)
    wr(0, 8'h01);
    irq_pin[0] = 1; tick(5);
    check("R7 vec pin0", irq_vec, 16);

    // R10: polarity flips on steady pins
    wr(3, 8'h00);
    wr(0, 8'h1E); tick(2); wr(0, 8'h01); tick(5);
    rd(3, d); check("R10 no false edge", d, 0);

    // R5: write 1 keeps flag, edge beats clear
    irq_pin[0] = 0; tick(3); irq_pin[0] = 1; tick(5);
    wr(3, 8'hFF); rd(3, d); check("R5 write1 keeps", d, 8'h01);
    irq_pin[0] = 0; tick(3); wr(0, 8'h00); // falling on pin0 now
    irq_pin[0] = 1; tick(5);
    @(negedge clk); irq_pin[0] = 0;
    @(negedge clk); @(negedge clk); wr_en = 1; wr_addr = 3; wr_data = 8'h00;
    @(negedge clk); wr_en = 0;
    rd(3, d); check("R5 edge beats clear", d, 8'h01);
    wr(3, 8'h00); rd(3, d); check("R5 clear", d, 0);

    // R2/R3/R9: NMI rising
    wr(0, 8'h10); cpu_imask = 1;
    irq_pin[2] = 1; tick(5);
    nmi_pin = 1; tick(5);
    rd(3, d); check("R2 nmi pending", d[4], 1);
    check("R3 nmi vec", irq_vec, 7);
    check("R3 nmi under mask", irq_req, 1);
    wr(3, 8'h00); rd(3, d); check("R5 bit4 write ignored", d[4], 1);
    ack(); rd(3, d); check("R9 ack clears", d[4], 0);
    check("R9 req gone", irq_req, 0);
    cpu_imask = 0;

    // random phase
    void'($urandom(32'h1234));
    wr(0, 0); wr(1, 0); wr(2, 0); wr(3, 0);
    lvl = {nmi_pin, irq_pin}; pol = 0; pfn = 0; en = 0; fl = 0; nmi = 0;
    for (int it = 0; it < 150; it++) begin
      if ($urandom_range(0, 3) == 0) begin pol = 5'($urandom); wr(0, {3'b0, pol}); end
      if ($urandom_range(0, 3) == 0) begin pfn = 4'($urandom); wr(1, {4'b0, pfn}); end
      if ($urandom_range(0, 3) == 0) begin en = 4'($urandom); wr(2, {4'b0, en}); end
      tick(4);
      nl = 5'($urandom);
      {nmi_pin, irq_pin} = nl;
      rise = nl & ~lvl; fall = lvl & ~nl;
      det = (pol & rise) | (~pol & fall);
      fl = fl | (det[3:0] & pfn);
      nmi = nmi | det[4];
      lvl = nl;
      im = 1'($urandom); cpu_imask = im;
      tick(5);
      rd(3, d);
      check("R4 rnd flags", d[3:0], fl);
      check("R2 rnd nmi", d[4], nmi);
      check("R7 rnd req", {irq_req, irq_vec}, exp_out(nmi, fl, en, im));
      if ($urandom_range(0, 2) == 0) begin
        d = 8'($urandom); wr(3, d); fl = fl & d[3:0];
      end
      if (nmi && $urandom_range(0, 1) == 0) begin ack(); nmi = 0; end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule